// File: doc/BRIEF.md
# Alarm Time Keeper with Snooze

This block keeps two 24-hour times in BCD: a running clock time and a settable alarm time. It also decides when the alarm sounds. Everything is clocked by the system clock. The one-second tick and the alarm-setting tick come in as level signals, and the block turns the rising edge of each into a single-cycle event. The clock time moves forward on every second event, whether or not the alarm is being set. The alarm time moves forward only on alarm-setting events while alarm-set mode is on. The four display digits show the alarm time while alarm-set mode is on, and the clock time otherwise.

The alarm starts ringing when, with the alarm enabled, the clock hours and minutes come to equal the alarm hours and minutes. Ringing then lasts for a window of `RING_SECONDS` ringing seconds. An active-low snooze press is honoured only while the alarm rings and neither set mode is on. It silences the ring for `SNOOZE_TICKS` second events, and those silent seconds do not use up the window. Turning the alarm off ends the window for good: turning it back on stays quiet until the times next come to match. The active-low reset returns both times to 00:00, clears any snooze and leaves the window closed.

Top module: `alarm_timekeeper`

## Requirements
- R1: Each time keeps a seconds count from 0 to SEC_PER_MIN-1 that carries into BCD minutes. Minutes 59 carry into the hours, and 23:59 wraps to 00:00.
- R2: The clock time advances once per rising edge of `sec_tick`, in every mode, including while `aset_mode` is 1.
- R3: The alarm time advances once per rising edge of `aset_tick` only while `aset_mode` is 1. At all other times it holds its value.
- R4: The outputs `hr_tens`, `hr_units`, `min_tens` and `min_units` are 4-bit BCD digits, where `hr_tens` is 0 to 2 and `min_tens` is 0 to 5. They show the alarm time while `aset_mode` is 1 and the clock time while it is 0.
- R5: With `alarm_en` at 1, the clock cycle after the clock hh:mm comes to equal the alarm hh:mm, `ring` goes to 1 and the ring window restarts from zero.
- R6: `ring` stays at 1 for RING_SECONDS second events counted while ringing, and drops to 0 at the last of them.
- R7: A snooze press (`snooze_n` at 0, with `ring` at 1 and both `aset_mode` and `cset_mode` at 0) drives `ring` to 0 from the next cycle. Ringing resumes at the SNOOZE_TICKS-th second event after the press. Snoozed seconds do not count toward the window.
- R8: A snooze press while `aset_mode` or `cset_mode` is 1 has no effect: `ring` stays at 1.
- R9: With `alarm_en` at 0, `ring` is 0 and the window is closed. Setting `alarm_en` back to 1 does not make `ring` go to 1 until the next time match.
- R10: While `rst_n` is 0, both times become 00:00, any snooze is cleared and `ring` is 0. Right after reset, the equal times do not start a ring.
- R11: A tick input held high for many cycles counts as one event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-second tick level; its rising edge advances the clock time |
| aset_tick | input | 1 | Alarm-setting tick level; its rising edge advances the alarm time in alarm-set mode |
| aset_mode | input | 1 | 1 = alarm-set mode (alarm time shown and adjustable) |
| cset_mode | input | 1 | 1 = clock-set mode (blocks snooze) |
| alarm_en | input | 1 | 1 = alarm enabled |
| snooze_n | input | 1 | Active-low snooze button |
| hr_tens | output | 4 | BCD hours tens digit |
| hr_units | output | 4 | BCD hours units digit |
| min_tens | output | 4 | BCD minutes tens digit |
| min_units | output | 4 | BCD minutes units digit |
| ring | output | 1 | Alarm sounding |

## Verification
The bench builds the block with SEC_PER_MIN=2, RING_SECONDS=8 and SNOOZE_TICKS=3. A full 24-hour turn of the clock, including the 23:59 to 00:00 wrap and a second alarm match on the next day, then fits in a few thousand cycles. The shortened window lets the bench watch the ring expire, sit through a complete snooze, and see the window carry on afterwards with its remaining seconds intact.

// File: rtl/atk_pkg.sv
package atk_pkg;

   // Hours and minutes held as four BCD digits.
   typedef struct packed {
      logic [3:0] hr_t;
      logic [3:0] hr_u;
      logic [3:0] mn_t;
      logic [3:0] mn_u;
   } hhmm_t;

   localparam logic [3:0] DIG_NINE     = 4'd9;
   localparam logic [3:0] MIN_TENS_TOP = 4'd5;
   localparam logic [3:0] HR_TENS_TOP  = 4'd2;
   localparam logic [3:0] HR_UNITS_TOP = 4'd3;
   localparam hhmm_t      MIDNIGHT     = '0;

   // Moves a time forward by one minute, wrapping 23:59 to 00:00.
   function automatic hhmm_t bump_minute(input hhmm_t t);
      hhmm_t n;
      n = t;
      if (t.mn_u != DIG_NINE) begin
         n.mn_u = t.mn_u + 4'd1;
      end else begin
         n.mn_u = 4'd0;
         if (t.mn_t != MIN_TENS_TOP) begin
            n.mn_t = t.mn_t + 4'd1;
         end else begin
            n.mn_t = 4'd0;
            if (t.hr_t == HR_TENS_TOP && t.hr_u == HR_UNITS_TOP) begin
               n.hr_t = 4'd0;
               n.hr_u = 4'd0;
            end else if (t.hr_u == DIG_NINE) begin
               n.hr_u = 4'd0;
               n.hr_t = t.hr_t + 4'd1;
            end else begin
               n.hr_u = t.hr_u + 4'd1;
            end
         end
      end
      return n;
   endfunction

endpackage

// File: rtl/atk_tick_edge.sv
module atk_tick_edge #(
   parameter int EDGE_DETECT = 1   // 1: input is a level, take its rising edge; 0: input is already a pulse
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_in,
   output logic tick_evt
);

   generate
      if (EDGE_DETECT != 0) begin : g_edge
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= tick_in;
         end
         assign tick_evt = tick_in & ~prev_q;
      end else begin : g_pass
         assign tick_evt = tick_in;
      end
   endgenerate

endmodule

// File: rtl/atk_time_reg.sv
module atk_time_reg
   import atk_pkg::*;
#(
   parameter int SEC_PER_MIN = 60
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  adv,
   output hhmm_t time_o
);

   localparam int SEC_W = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
   localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_MIN - 1);
   localparam logic [SEC_W-1:0] SEC_ONE  = SEC_W'(1);

   logic [SEC_W-1:0] sec_q;
   hhmm_t            hm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q <= '0;
         hm_q  <= MIDNIGHT;
      end else if (adv) begin
         if (sec_q == SEC_LAST) begin
            sec_q <= '0;
            hm_q  <= bump_minute(hm_q);
         end else begin
            sec_q <= sec_q + SEC_ONE;
         end
      end
   end

   assign time_o = hm_q;

endmodule

// File: rtl/atk_ring_ctrl.sv
module atk_ring_ctrl #(
   parameter int RING_SECONDS = 1800,
   parameter int SNOOZE_TICKS = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sec_evt,
   input  logic alarm_en,
   input  logic match,
   input  logic snooze_ok,
   input  logic snooze_n,
   output logic ring
);

   localparam int RT_W = $clog2(RING_SECONDS + 1);
   localparam int SN_W = $clog2(SNOOZE_TICKS + 1);
   localparam logic [RT_W-1:0] RT_DONE = RT_W'(RING_SECONDS);
   localparam logic [RT_W-1:0] RT_ONE  = RT_W'(1);
   localparam logic [SN_W-1:0] SN_FULL = SN_W'(SNOOZE_TICKS);
   localparam logic [SN_W-1:0] SN_ONE  = SN_W'(1);

   logic [RT_W-1:0] rt_q;
   logic [SN_W-1:0] snz_q;
   logic            match_q;
   logic            ring_c;
   logic            restart;
   logic            snz_start;

   assign ring_c    = alarm_en && (rt_q < RT_DONE) && (snz_q == '0);
   assign restart   = alarm_en && match && !match_q;
   assign snz_start = snooze_ok && ring_c && !snooze_n;

   // Ring window timer: closed when disabled, reopened on a new match,
   // counts only seconds spent actually ringing.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rt_q    <= RT_DONE;
         match_q <= 1'b1;
      end else begin
         match_q <= match;
         if (!alarm_en)              rt_q <= RT_DONE;
         else if (restart)           rt_q <= '0;
         else if (sec_evt && ring_c) rt_q <= rt_q + RT_ONE;
      end
   end

   // Snooze interval, measured in second events.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         snz_q <= '0;
      else if (snz_start)                 snz_q <= SN_FULL;
      else if (sec_evt && snz_q != '0)    snz_q <= snz_q - SN_ONE;
   end

   assign ring = ring_c;

endmodule

// File: rtl/alarm_timekeeper.sv
module alarm_timekeeper
   import atk_pkg::*;
#(
   parameter int SEC_PER_MIN  = 60,
   parameter int RING_SECONDS = 1800,
   parameter int SNOOZE_TICKS = 6,
   parameter int EDGE_DETECT  = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sec_tick,
   input  logic       aset_tick,
   input  logic       aset_mode,
   input  logic       cset_mode,
   input  logic       alarm_en,
   input  logic       snooze_n,
   output logic [3:0] hr_tens,
   output logic [3:0] hr_units,
   output logic [3:0] min_tens,
   output logic [3:0] min_units,
   output logic       ring
);

   generate
      if (SEC_PER_MIN < 2) begin : g_bad_spm
         $error("SEC_PER_MIN must be at least 2");
      end
      if (RING_SECONDS < 1) begin : g_bad_ring
         $error("RING_SECONDS must be at least 1");
      end
      if (SNOOZE_TICKS < 1) begin : g_bad_snz
         $error("SNOOZE_TICKS must be at least 1");
      end
   endgenerate

   logic  sec_evt;
   logic  aset_raw_evt;
   logic  aset_evt;
   hhmm_t clk_time;
   hhmm_t alm_time;
   hhmm_t shown;
   logic  match;
   logic  snooze_ok;

   atk_tick_edge #(.EDGE_DETECT(EDGE_DETECT)) u_sec_edge (
      .clk(clk), .rst_n(rst_n), .tick_in(sec_tick), .tick_evt(sec_evt)
   );

   atk_tick_edge #(.EDGE_DETECT(EDGE_DETECT)) u_aset_edge (
      .clk(clk), .rst_n(rst_n), .tick_in(aset_tick), .tick_evt(aset_raw_evt)
   );

   assign aset_evt = aset_raw_evt & aset_mode;

   atk_time_reg #(.SEC_PER_MIN(SEC_PER_MIN)) u_clock_time (
      .clk(clk), .rst_n(rst_n), .adv(sec_evt), .time_o(clk_time)
   );

   atk_time_reg #(.SEC_PER_MIN(SEC_PER_MIN)) u_alarm_time (
      .clk(clk), .rst_n(rst_n), .adv(aset_evt), .time_o(alm_time)
   );

   assign match     = (clk_time == alm_time);
   assign snooze_ok = !aset_mode && !cset_mode;

   atk_ring_ctrl #(.RING_SECONDS(RING_SECONDS), .SNOOZE_TICKS(SNOOZE_TICKS)) u_ring (
      .clk(clk), .rst_n(rst_n), .sec_evt(sec_evt), .alarm_en(alarm_en),
      .match(match), .snooze_ok(snooze_ok), .snooze_n(snooze_n), .ring(ring)
   );

   assign shown     = aset_mode ? alm_time : clk_time;
   assign hr_tens   = shown.hr_t;
   assign hr_units  = shown.hr_u;
   assign min_tens  = shown.mn_t;
   assign min_units = shown.mn_u;

endmodule

// File: rtl/atk_checker.sv
module atk_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       sec_evt,
   input logic       aset_evt,
   input logic       aset_mode,
   input logic       cset_mode,
   input logic       alarm_en,
   input logic       snooze_n,
   input logic       ring,
   input logic [3:0] hr_tens,
   input logic [3:0] hr_units,
   input logic [3:0] min_tens,
   input logic [3:0] min_units
);

   logic [15:0] digits;
   assign digits = {hr_tens, hr_units, min_tens, min_units};

   p_digits_legal_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (hr_units <= 4'd9) && (min_units <= 4'd9) && (min_tens <= 4'd5) &&
      (hr_tens <= 4'd2) && ((hr_tens != 4'd2) || (hr_units <= 4'd3)))
      else $error("digits out of BCD range");

   p_clock_hold_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (!aset_mode && !sec_evt) |=> (aset_mode || $stable(digits)))
      else $error("clock time moved without a second event");

   p_alarm_hold_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (aset_mode && !aset_evt) |=> (!aset_mode || $stable(digits)))
      else $error("alarm time moved without a setting event");

   p_ring_hold_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (ring && !sec_evt && snooze_n) |=> (ring || !alarm_en))
      else $error("ring dropped without a second event");

   p_snooze_mute_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (!aset_mode && !cset_mode && ring && !snooze_n) |=> !ring)
      else $error("accepted snooze did not silence ring");

   p_snooze_blocked_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      ((aset_mode || cset_mode) && ring && !snooze_n && !sec_evt) |=> (ring || !alarm_en))
      else $error("snooze acted inside a set mode");

   p_disable_quiet_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      !alarm_en |=> !ring)
      else $error("ring after alarm disabled");

endmodule

bind alarm_timekeeper atk_checker u_atk_checker (
   .clk(clk), .rst_n(rst_n), .sec_evt(sec_evt), .aset_evt(aset_evt),
   .aset_mode(aset_mode), .cset_mode(cset_mode), .alarm_en(alarm_en),
   .snooze_n(snooze_n), .ring(ring), .hr_tens(hr_tens), .hr_units(hr_units),
   .min_tens(min_tens), .min_units(min_units)
);

// File: tb/alarm_timekeeper_bench.sv
`timescale 1ns/1ps
module alarm_timekeeper_bench;

   localparam int SPM  = 2;
   localparam int RING = 8;
   localparam int SNZ  = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sec_tick = 1'b0, aset_tick = 1'b0, aset_mode = 1'b0, cset_mode = 1'b0;
   logic alarm_en = 1'b0, snooze_n = 1'b1;
   logic [3:0] hr_tens, hr_units, min_tens, min_units;
   logic ring;

   int tests = 0;
   int fails = 0;
   string cur_req = "R10";
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   alarm_timekeeper #(.SEC_PER_MIN(SPM), .RING_SECONDS(RING), .SNOOZE_TICKS(SNZ)) u_alarm_timekeeper (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .aset_tick(aset_tick),
      .aset_mode(aset_mode), .cset_mode(cset_mode), .alarm_en(alarm_en),
      .snooze_n(snooze_n), .hr_tens(hr_tens), .hr_units(hr_units),
      .min_tens(min_tens), .min_units(min_units), .ring(ring)
   );

   // Behavioural reference: minutes of day as integers.
   int  c_sec, c_min, a_sec, a_min, m_rt, m_snz;
   bit  m_match_prev, m_sec_prev, m_aset_prev;

   function automatic bit model_ring();
      return alarm_en && (m_rt < RING) && (m_snz == 0);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         c_sec = 0; c_min = 0; a_sec = 0; a_min = 0;
         m_rt = RING; m_snz = 0;
         m_match_prev = 1'b1; m_sec_prev = 1'b0; m_aset_prev = 1'b0;
      end else begin
         bit sev, aev, mt, rg;
         sev = sec_tick && !m_sec_prev;
         aev = aset_tick && !m_aset_prev && aset_mode;
         mt  = (c_min == a_min);
         rg  = model_ring();
         if (!alarm_en)           m_rt = RING;
         else if (mt && !m_match_prev) m_rt = 0;
         else if (sev && rg)      m_rt = m_rt + 1;
         if (!aset_mode && !cset_mode && rg && !snooze_n) m_snz = SNZ;
         else if (sev && m_snz > 0) m_snz = m_snz - 1;
         if (sev) begin
            c_sec = c_sec + 1;
            if (c_sec == SPM) begin c_sec = 0; c_min = (c_min + 1) % 1440; end
         end
         if (aev) begin
            a_sec = a_sec + 1;
            if (a_sec == SPM) begin a_sec = 0; a_min = (a_min + 1) % 1440; end
         end
         m_match_prev = mt;
         m_sec_prev   = sec_tick;
         m_aset_prev  = aset_tick;
      end
   end

   function automatic logic [15:0] to_bcd(input int mins);
      int hh, mm;
      hh = mins / 60;
      mm = mins % 60;
      return {4'(hh / 10), 4'(hh % 10), 4'(mm / 10), 4'(mm % 10)};
   endfunction

   // Per-cycle comparison against the reference, mid low phase.
   always @(negedge clk) begin
      #2;
      if (rst_n && !done) begin
         logic [15:0] exp_d, act_d;
         bit exp_r;
         exp_d = to_bcd(aset_mode ? a_min : c_min);
         exp_r = model_ring();
         act_d = {hr_tens, hr_units, min_tens, min_units};
         tests++;
         if (act_d !== exp_d || ring !== exp_r) begin
            fails++;
            $display("FAIL %s model: digits=%h ring=%b expected digits=%h ring=%b",
                     cur_req, act_d, ring, exp_d, exp_r);
         end
      end
   end

   task automatic chk(input string req, input int hh, input int mm, input bit rg);
      logic [15:0] exp_d, act_d;
      #3;
      exp_d = to_bcd(hh * 60 + mm);
      act_d = {hr_tens, hr_units, min_tens, min_units};
      tests++;
      if (act_d !== exp_d || ring !== rg) begin
         fails++;
         $display("FAIL %s: digits=%h ring=%b expected digits=%h ring=%b",
                  req, act_d, ring, exp_d, rg);
      end
      @(negedge clk);
   endtask

   task automatic tick_sec(input int n);
      for (int i = 0; i < n; i++) begin
         sec_tick = 1'b1; @(negedge clk);
         sec_tick = 1'b0; @(negedge clk);
      end
   endtask

   task automatic tick_alarm(input int n);
      for (int i = 0; i < n; i++) begin
         aset_tick = 1'b1; @(negedge clk);
         aset_tick = 1'b0; @(negedge clk);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R10", 0, 0, 1'b0);            // under reset
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10", 0, 0, 1'b0);            // equal times after reset do not ring

      cur_req = "R11";                    // held tick counts once
      sec_tick = 1'b1;
      repeat (6) @(negedge clk);
      sec_tick = 1'b0;
      @(negedge clk);
      tick_sec(1);
      chk("R11", 0, 1, 1'b0);

      cur_req = "R3";
      tick_alarm(4);                      // ignored outside alarm-set mode
      aset_mode = 1'b1;
      chk("R3", 0, 0, 1'b0);
      tick_alarm(10);
      chk("R3", 0, 5, 1'b0);

      cur_req = "R2";
      tick_sec(2);                        // clock runs during alarm setting
      chk("R4", 0, 5, 1'b0);
      aset_mode = 1'b0;
      chk("R2", 0, 2, 1'b0);

      cur_req = "R5";
      alarm_en = 1'b1;
      tick_sec(6);
      chk("R5", 0, 5, 1'b1);

      cur_req = "R8";
      tick_sec(2);
      cset_mode = 1'b1; snooze_n = 1'b0;
      @(negedge clk);
      snooze_n = 1'b1; cset_mode = 1'b0;
      chk("R8", 0, 6, 1'b1);

      cur_req = "R7";
      snooze_n = 1'b0;
      @(negedge clk);
      snooze_n = 1'b1;
      chk("R7", 0, 6, 1'b0);
      tick_sec(2);
      chk("R7", 0, 7, 1'b0);
      tick_sec(1);
      chk("R7", 0, 7, 1'b1);

      cur_req = "R6";
      tick_sec(5);
      chk("R6", 0, 10, 1'b1);
      tick_sec(1);
      chk("R6", 0, 10, 1'b0);

      cur_req = "R1";
      tick_sec(2858);
      chk("R1", 23, 59, 1'b0);
      tick_sec(1);
      chk("R1", 0, 0, 1'b0);
      tick_sec(10);
      chk("R5", 0, 5, 1'b1);

      cur_req = "R9";
      alarm_en = 1'b0;
      @(negedge clk);
      chk("R9", 0, 5, 1'b0);
      tick_sec(2);
      alarm_en = 1'b1;
      @(negedge clk);
      chk("R9", 0, 6, 1'b0);
      tick_sec(3);
      chk("R9", 0, 7, 1'b0);

      cur_req = "R10";
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk("R10", 0, 0, 1'b0);
      aset_mode = 1'b1;
      chk("R10", 0, 0, 1'b0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule